// File: doc/BRIEF.md
# Framed Serial DAC Code Receiver

This block takes a three-wire synchronous serial stream (a bit clock, an active-low frame sync and a data line) and turns each complete frame into a parallel conversion code for a DAC holding register. A frame carries a 16-bit word, most significant bit first. The leading 14 bits become the DAC code. The final two bits are received and then dropped. All three serial inputs are brought into the system clock domain through a synchronizer chain. Bit-clock rising edges and sync edges are then detected on the system clock, so the bit clock must run well below the system clock.

The block also enforces the framing rules on the sync line. A sync low pulse that does not stay low for at least the first two bit-clock rising edges is a runt. A sync falling edge that arrives before the current word's last bit has been captured is early. Either violation discards the word, leaves the DAC code as it was, and raises an error flag with a cause code. The next word that completes correctly clears the flag.

The controller has four states. IDLE waits for a sync falling edge; the transition IDLE->QUAL is taken on that edge. QUAL captures the first two bits while checking that sync is still low. QUAL->SHIFT is taken once the second bit is in. QUAL->IDLE (runt) is taken if sync is seen high. SHIFT captures the remaining bits while sync is free to rise. SHIFT->IDLE (commit) is taken on the sixteenth bit. SHIFT->DROP (early) is taken on a sync falling edge. DROP ignores everything until sync is high again, and then takes DROP->IDLE.

Top module: `dac_frame_rx`

## Requirements
- R1: Serial data is sampled on bit-clock rising edges. A word starts only at a falling edge of `fsync_n`. Bit-clock rising edges seen before that falling edge, or in the same system cycle as it, are not part of the word.
- R2: The first bit after the sync falling edge goes to `dac_code[13]`. Each following bit goes to the next lower position, down to the fourteenth bit, which goes to `dac_code[0]`.
- R3: Bits 15 and 16 of a word have no effect on `dac_code`. `dac_code` changes only in a cycle where `dac_load` is high.
- R4: When the sixteenth rising edge of a word is captured, `dac_code` takes the new value and `dac_load` is high for exactly one system clock. This happens three system clocks after that edge reaches the `bclk` pin.
- R5: `fsync_n` must be low at the word's first two bit-clock rising edges. If it is seen high earlier than that, there is no load, `frame_err` becomes 1 and `err_cause` becomes 1 (runt). A pulse with no bit-clock edge at all also counts as a runt.
- R6: A falling edge of `fsync_n` after the second bit of a word but before its sixteenth bit is early. The word is dropped, `dac_code` is kept, `frame_err` becomes 1 and `err_cause` becomes 2. The frame begun by that edge is ignored until `fsync_n` returns high.
- R7: Once the first two bits are in, `fsync_n` may rise at any point without disturbing the word.
- R8: A successful load sets `frame_err` to 0 and `err_cause` to 0. Without a load, both keep their error value. `frame_err` is 1 exactly when `err_cause` is nonzero.
- R9: `rst_n` low asynchronously clears `dac_code`, `dac_load`, `frame_err` and `err_cause`, and discards any word in progress.
- R10: After a word completes, further bit-clock edges while `fsync_n` stays low start no new word and produce no load. A new word needs a fresh sync falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| fsync_n | input | 1 | Active-low frame sync |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 14 | DAC holding-register code |
| dac_load | output | 1 | One-cycle strobe when `dac_code` is updated |
| frame_err | output | 1 | Framing violation seen since the last good load |
| err_cause | output | 2 | 0 none, 1 runt sync pulse, 2 early sync edge |

## Verification
The bench targets several failure modes:
- A sync pulse released after one bit, and a pulse with no bit edges. A receiver that skipped the low-time check would load a garbage code.
- A sync falling edge landing in the middle of a word. A receiver that restarted on it would load part of the old word or take the second frame.
- Words that differ only in their two trailing bits. A wrong slice would show up as a changed code.
- Bit-clock pulses kept running after a word while sync stays low, and bit-clock edges before the frame. A receiver without edge qualification would load spurious words.
- A reset in mid-frame, followed by sync released at the earliest legal point. A receiver that kept stale count state, or that enforced sync low for the whole word, would fail here.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUAL  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DROP  = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RUNT  = 2'd1,
        CAUSE_EARLY = 2'd2
    } err_cause_t;

endpackage

// File: rtl/fdr_sync.sv
module fdr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fdr_shift.sv
module fdr_shift #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 14,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [CNT_W-1:0]  cnt,
    output logic [CODE_W-1:0] code_next
);

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] word_next;

    assign word_next = {sh[WORD_W-2:0], bit_in};
    assign code_next = word_next[WORD_W-1 -: CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= word_next;
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fdr_fsm.sv
module fdr_fsm
    import fdr_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int QUAL_BITS = 2,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_fall,
    input  logic             sync_high,
    input  logic             bit_rise,
    input  logic [CNT_W-1:0] cnt,
    output rx_state_t        state,
    output logic             clr,
    output logic             shift_en,
    output logic             commit,
    output logic             flag_runt,
    output logic             flag_early
);

    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_BITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    rx_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sync_fall) state_nx = ST_QUAL;
            end
            ST_QUAL: begin
                if (sync_high)                         state_nx = ST_IDLE;
                else if (bit_rise && cnt == QUAL_LAST) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sync_fall)                         state_nx = ST_DROP;
                else if (bit_rise && cnt == WORD_LAST) state_nx = ST_IDLE;
            end
            ST_DROP: begin
                if (sync_high) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clr        = 1'b0;
        shift_en   = 1'b0;
        commit     = 1'b0;
        flag_runt  = 1'b0;
        flag_early = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr = sync_fall;
            end
            ST_QUAL: begin
                flag_runt = sync_high;
                shift_en  = !sync_high && bit_rise;
            end
            ST_SHIFT: begin
                flag_early = sync_fall;
                shift_en   = !sync_fall && bit_rise;
                commit     = !sync_fall && bit_rise && (cnt == WORD_LAST);
            end
            ST_DROP: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import fdr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CODE_W      = 14,
    parameter int QUAL_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync_n,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_load,
    output logic              frame_err,
    output logic [1:0]        err_cause
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic b_q, b_qp, s_q, s_qp, d_q;
    logic b_rise, s_fall, s_high;
    logic clr, shift_en, commit, flag_runt, flag_early;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] code_next;
    rx_state_t         fsm_state;

    fdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bclk (
        .clk(clk), .rst_n(rst_n), .din(bclk), .q(b_q)
    );
    fdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_fs (
        .clk(clk), .rst_n(rst_n), .din(fsync_n), .q(s_q)
    );
    fdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sd (
        .clk(clk), .rst_n(rst_n), .din(sdin), .q(d_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_qp <= 1'b0;
            s_qp <= 1'b1;
        end else begin
            b_qp <= b_q;
            s_qp <= s_q;
        end
    end

    assign b_rise = b_q & ~b_qp;
    assign s_fall = ~s_q & s_qp;
    assign s_high = s_q;

    fdr_fsm #(.WORD_W(WORD_W), .QUAL_BITS(QUAL_BITS), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sync_fall(s_fall), .sync_high(s_high), .bit_rise(b_rise), .cnt(cnt),
        .state(fsm_state), .clr(clr), .shift_en(shift_en), .commit(commit),
        .flag_runt(flag_runt), .flag_early(flag_early)
    );

    fdr_shift #(.WORD_W(WORD_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .bit_in(d_q), .cnt(cnt), .code_next(code_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code <= '0;
            dac_load <= 1'b0;
        end else begin
            dac_load <= commit;
            if (commit) dac_code <= code_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else if (commit) begin
            frame_err <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else if (flag_runt) begin
            frame_err <= 1'b1;
            err_cause <= CAUSE_RUNT;
        end else if (flag_early) begin
            frame_err <= 1'b1;
            err_cause <= CAUSE_EARLY;
        end
    end

endmodule

// File: rtl/fdr_checker.sv
module fdr_checker
    import fdr_pkg::*;
#(
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input rx_state_t         state,
    input logic              sync_fall,
    input logic              sync_high,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_load,
    input logic              frame_err,
    input logic [1:0]        err_cause
);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);

    p_code_moves_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> dac_load);

    p_load_from_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> ($past(state) == ST_SHIFT));

    p_load_clears_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> (!frame_err && err_cause == CAUSE_NONE));

    p_flag_cause_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err == (err_cause != CAUSE_NONE));

    p_runt_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && sync_high) |=>
            (frame_err && err_cause == CAUSE_RUNT && !dac_load));

    p_early_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sync_fall) |=>
            (frame_err && err_cause == CAUSE_EARLY && !dac_load));

endmodule

bind dac_frame_rx fdr_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(fsm_state),
    .sync_fall(s_fall), .sync_high(s_high),
    .dac_code(dac_code), .dac_load(dac_load),
    .frame_err(frame_err), .err_cause(err_cause)
);

// File: tb/sim_dac_frame_rx.sv
`timescale 1ns/1ps
module sim_dac_frame_rx;

    localparam int WORD_W = 16;
    localparam int CODE_W = 14;
    localparam int S      = 2;
    localparam int HALF   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync_n = 1'b1, sdin = 1'b0;
    logic [CODE_W-1:0] dac_code;
    logic dac_load, frame_err;
    logic [1:0] err_cause;

    int checks = 0, fails = 0, loads = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dac_frame_rx #(.WORD_W(WORD_W), .CODE_W(CODE_W), .QUAL_BITS(2), .SYNC_STAGES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync_n(fsync_n), .sdin(sdin),
        .dac_code(dac_code), .dac_load(dac_load), .frame_err(frame_err), .err_cause(err_cause)
    );

    // behavioural reference: input history delayed by the synchronizer depth
    logic hb[$], hs[$], hd[$];
    int m_st, m_cnt, m_word, m_code, m_cause;
    bit m_load, m_err;

    task automatic model_reset();
        hb = {}; hs = {}; hd = {};
        for (int i = 0; i <= S; i++) begin hb.push_back(1'b0); hs.push_back(1'b1); hd.push_back(1'b0); end
        m_st = 0; m_cnt = 0; m_word = 0; m_code = 0; m_cause = 0; m_load = 0; m_err = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else begin
            logic cb, pb, cs, ps, cd;
            bit rise, fall;
            cb = hb[S-1]; pb = hb[S]; cs = hs[S-1]; ps = hs[S]; cd = hd[S-1];
            rise = cb && !pb; fall = ps && !cs;
            m_load = 0;
            case (m_st)
                0: if (fall) begin m_st = 1; m_cnt = 0; m_word = 0; end
                1: if (cs) begin m_err = 1; m_cause = 1; m_st = 0; end
                   else if (rise) begin
                       m_word = (m_word << 1) | int'(cd); m_cnt++;
                       if (m_cnt == 2) m_st = 2;
                   end
                2: if (fall) begin m_err = 1; m_cause = 2; m_st = 3; end
                   else if (rise) begin
                       m_word = (m_word << 1) | int'(cd); m_cnt++;
                       if (m_cnt == WORD_W) begin
                           m_code = (m_word >> (WORD_W - CODE_W)) & ((1 << CODE_W) - 1);
                           m_load = 1; m_err = 0; m_cause = 0; m_st = 0;
                       end
                   end
                default: if (cs) m_st = 0;
            endcase
            void'(hb.pop_back()); void'(hs.pop_back()); void'(hd.pop_back());
            hb.push_front(bclk); hs.push_front(fsync_n); hd.push_front(sdin);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dac_load) loads++;
            chk(int'(dac_code) == m_code, "R2 code", int'(dac_code), m_code);
            chk(dac_load == m_load, "R4 load", int'(dac_load), int'(m_load));
            chk(frame_err == m_err, "R8 flag", int'(frame_err), int'(m_err));
            chk(int'(err_cause) == m_cause, "R6 cause", int'(err_cause), m_cause);
        end
    end

    task automatic bit_pulse(input logic d, input bit rel);
        @(negedge clk) begin sdin = d; bclk = 1'b0; end
        repeat (HALF - 1) @(negedge clk);
        @(negedge clk) bclk = 1'b1;
        @(negedge clk);
        @(negedge clk) if (rel) fsync_n = 1'b1;
        repeat (HALF - 3) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, input int rel_after, input bit hold_end);
        @(negedge clk) fsync_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) bit_pulse(w[15-i], (i + 1) == rel_after);
        @(negedge clk) begin bclk = 1'b0; if (!hold_end) fsync_n = 1'b1; end
    endtask

    task automatic expect_state(input string req, input int code, input bit err, input int cause);
        repeat (6) @(negedge clk);
        chk(int'(dac_code) == code, {req, " code"}, int'(dac_code), code);
        chk(frame_err == err, {req, " frame_err"}, int'(frame_err), int'(err));
        chk(int'(err_cause) == cause, {req, " err_cause"}, int'(err_cause), cause);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int l0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(dac_code == '0 && !dac_load && !frame_err && err_cause == 2'd0, "R9 reset", int'(dac_code), 0);

        // R1: bit-clock edges with sync high are ignored
        for (int i = 0; i < 5; i++) bit_pulse(1'b1, 0);
        expect_state("R1 idle edges", 0, 0, 0);

        // R2 / R4: plain word, MSB first
        l0 = loads;
        frame(16'hA5C3, 16, 16, 0);
        expect_state("R2 word1", 16'hA5C3 >> 2, 0, 0);
        chk(loads - l0 == 1, "R4 one load", loads - l0, 1);

        frame(16'h5A3C, 16, 16, 0);
        expect_state("R2 word2", 16'h5A3C >> 2, 0, 0);

        // R3: trailing bits differ only
        l0 = loads;
        frame(16'h1234 | 16'h3, 16, 16, 0);
        expect_state("R3 tail set", 16'h1234 >> 2, 0, 0);
        frame(16'h1234 & ~16'h3, 16, 16, 0);
        expect_state("R3 tail clear", 16'h1234 >> 2, 0, 0);
        chk(loads - l0 == 2, "R3 loads", loads - l0, 2);

        // R5: runt after one bit, bits keep running
        l0 = loads;
        frame(16'hFFFF, 16, 1, 0);
        expect_state("R5 runt one bit", 16'h1234 >> 2, 1, 1);
        chk(loads == l0, "R5 no load", loads - l0, 0);

        // R8: good word clears error
        frame(16'h8001, 16, 16, 0);
        expect_state("R8 clear", 16'h8001 >> 2, 0, 0);

        // R5: pulse with no bit edges
        frame(16'h0000, 0, 0, 0);
        expect_state("R5 runt zero bits", 16'h8001 >> 2, 1, 1);

        // R7: sync released right after the second bit, and after the third
        frame(16'hBEEF, 16, 2, 0);
        expect_state("R7 release at 2", 16'hBEEF >> 2, 0, 0);
        frame(16'h7FFE, 16, 3, 0);
        expect_state("R7 release at 3", 16'h7FFE >> 2, 0, 0);

        // R6: new fall before the word completes
        l0 = loads;
        frame(16'h0F0F, 10, 3, 0);
        frame(16'hF0F0, 16, 16, 0);
        expect_state("R6 early", 16'h7FFE >> 2, 1, 2);
        chk(loads == l0, "R6 no load", loads - l0, 0);
        frame(16'h3C3C, 16, 16, 0);
        expect_state("R6 recover", 16'h3C3C >> 2, 0, 0);

        // R10: sync held low after a word, extra edges do nothing
        l0 = loads;
        frame(16'hC0DE, 16, 0, 1);
        for (int i = 0; i < 16; i++) bit_pulse(1'b1, 0);
        @(negedge clk) fsync_n = 1'b1;
        expect_state("R10 held low", 16'hC0DE >> 2, 0, 0);
        chk(loads - l0 == 1, "R10 single load", loads - l0, 1);

        // R9: reset in mid-frame
        frame(16'hAAAA, 8, 0, 1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        chk(dac_code == '0 && !dac_load && !frame_err && err_cause == 2'd0, "R9 mid reset", int'(dac_code), 0);
        @(negedge clk) fsync_n = 1'b1;
        @(posedge clk); #1 rst_n = 1'b1;
        frame(16'h4321, 16, 2, 0);
        expect_state("R9 after reset", 16'h4321 >> 2, 0, 0);

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule